// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the SPI serial clock from the module clock. A run-time select bit picks one of two division schemes. With the bit clear, the serial clock period is a power of two of module-clock cycles, set by a 4-bit exponent field. With the bit set, the period is an even number of cycles, `2 × (count + 1)`, set by an 8-bit count field. Alongside the serial clock it produces single-cycle strobes that mark each rising and each falling serial-clock transition, so that shift logic in the same module-clock domain can launch and capture data.

While the bus-enable input is low, the serial clock sits at the idle level given by the clock-polarity input and no strobes are produced. Divider settings are copied into a shadow copy while the block is disabled, and again each time the serial clock completes a full period and returns to its idle level. Changing the fields in the middle of a period therefore never produces a shortened pulse. An exponent of zero in the power-of-two scheme passes the module clock straight through.

Top module: `spi_dual_clkdiv`

## Requirements
- R1: While reset is asserted, `sclk_o` equals `cpol_i` and both strobes are low.
- R2: While `bus_en_i` is low, `sclk_o` equals `cpol_i` and both strobes stay low, whatever the divider fields hold.
- R3: With `div_sel_i` = 0 and `exp_div_i` = e (e ≥ 1), `sclk_o` has a period of 2^e module-clock cycles with a 50 % duty cycle.
- R4: With `div_sel_i` = 0 and `exp_div_i` = 0, the module clock passes through. While enabled, `sclk_o` = `cpol_i` XOR `clk_i`, and both strobes are high in every cycle.
- R5: With `div_sel_i` = 1 and `lin_div_i` = n, `sclk_o` has a period of 2·(n+1) module-clock cycles, for n from 0 to 255.
- R6: The select bit alone chooses the scheme. `lin_div_i` has no effect when `div_sel_i` = 0, and `exp_div_i` has no effect when `div_sel_i` = 1.
- R7: Divider settings that change while enabled take effect only once `sclk_o` has returned to its idle level at the end of the current period. The period in progress completes with its old half-period lengths.
- R8: Outside pass-through, `rise_stb_o` is high for exactly the one cycle after `sclk_o` goes from 0 to 1, and `fall_stb_o` likewise after it goes from 1 to 0. The two strobes are never high together.
- R9: With `cpol_i` = 1 the idle level is high, and the first transition of each period is a falling edge.
- R10: The maximum exponent, 15, gives a period of 32768 module-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Enables serial-clock generation |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_sel_i | input | 1 | 0: power-of-two divide, 1: linear even divide |
| exp_div_i | input | 4 | Power-of-two exponent |
| lin_div_i | input | 8 | Linear divide count n, period 2·(n+1) |
| sclk_o | output | 1 | Serial clock |
| rise_stb_o | output | 1 | One-cycle strobe after a rising transition |
| fall_stb_o | output | 1 | One-cycle strobe after a falling transition |

## Verification
The bench builds the block with its package default field widths: a 4-bit exponent and an 8-bit linear count. This brings within reach both extremes of each scheme: pass-through at exponent 0, a one-cycle half period at exponent 1 and at count 0, a 512-cycle period at count 255, and the 32768-cycle period at exponent 15. A behavioural model that computes half-period lengths arithmetically is compared against the outputs in every cycle. The bench also makes directed measurements of the gaps between strobes. Among these is a field change made just after a rising edge, which shows the old half period finishing before the new one applies.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    parameter int EXP_W  = 4;
    parameter int LIN_W  = 8;
    // widest half period: max of 2^(2^EXP_W - 1 - 1) and 2^LIN_W
    localparam int EXP_HALF_BITS = (1 << EXP_W) - 1;
    localparam int LIN_HALF_BITS = LIN_W + 1;
    parameter int HALF_W = (EXP_HALF_BITS > LIN_HALF_BITS) ? EXP_HALF_BITS : LIN_HALF_BITS;

    typedef struct packed {
        logic             lin_mode;
        logic [EXP_W-1:0] exp_val;
        logic [LIN_W-1:0] lin_val;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{lin_mode: 1'b0, exp_val: '0, lin_val: '0};

    function automatic logic cfg_is_bypass(input div_cfg_t c);
        return (!c.lin_mode) && (c.exp_val == '0);
    endfunction

    // number of module-clock cycles in one serial-clock half period
    function automatic logic [HALF_W-1:0] half_cycles(input div_cfg_t c);
        logic [HALF_W-1:0] h;
        if (c.lin_mode) begin
            h = HALF_W'(c.lin_val) + HALF_W'(1);
        end else if (c.exp_val == '0) begin
            h = HALF_W'(1);
        end else begin
            h = HALF_W'(1) << (c.exp_val - EXP_W'(1));
        end
        return h;
    endfunction

endpackage

// File: rtl/sclk_cfg_shadow.sv
module sclk_cfg_shadow
    import spi_clkdiv_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     load_i,
    input  div_cfg_t cfg_i,
    output div_cfg_t act_o
);

    div_cfg_t act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= CFG_RESET;
        end else if (load_i) begin
            act_q <= cfg_i;
        end
    end

    assign act_o = act_q;

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] half_len_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last   = (cnt_q == (half_len_i - CNT_W'(1)));
    assign tick_o = run_i && last;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // count never passes the active half-period length
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (cnt_q < half_len_i));

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bus_en_i,
    input  logic cpol_i,
    input  logic tick_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic lvl_q, rise_q, fall_q;
    logic next_pin;

    // pin level after a toggle: active level is the inverse of cpol
    assign next_pin = cpol_i ^ ~lvl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !bus_en_i) begin
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= tick_i && next_pin;
            fall_q <= tick_i && !next_pin;
            if (tick_i) begin
                lvl_q <= ~lvl_q;
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    p_off_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_en_i |=> (!lvl_q && !rise_q && !fall_q));

    p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rise_q && fall_q));

    p_rise_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_q |=> !rise_q);

    p_no_runt_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_en_i && !tick_i) |=> $stable(lvl_q));

endmodule

// File: rtl/spi_dual_clkdiv.sv
module spi_dual_clkdiv
    import spi_clkdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bus_en_i,
    input  logic             cpol_i,
    input  logic             div_sel_i,
    input  logic [EXP_W-1:0] exp_div_i,
    input  logic [LIN_W-1:0] lin_div_i,
    output logic             sclk_o,
    output logic             rise_stb_o,
    output logic             fall_stb_o
);

    div_cfg_t          cfg_in, act_cfg;
    logic              act_byp, load_cfg, timer_run, tick;
    logic              lvl, rise_q, fall_q;
    logic              run_q, byp_live;
    logic [HALF_W-1:0] half_len;

    assign cfg_in = '{lin_mode: div_sel_i, exp_val: exp_div_i, lin_val: lin_div_i};

    assign act_byp   = cfg_is_bypass(act_cfg);
    assign half_len  = half_cycles(act_cfg);
    assign timer_run = bus_en_i && !act_byp;
    // reload at idle: disabled, pass-through, or trailing edge of a period
    assign load_cfg  = !bus_en_i || act_byp || (tick && lvl);

    sclk_cfg_shadow u_shadow (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load_cfg),
        .cfg_i  (cfg_in),
        .act_o  (act_cfg)
    );

    sclk_half_timer #(.CNT_W(HALF_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .run_i      (timer_run),
        .half_len_i (half_len),
        .tick_o     (tick)
    );

    sclk_edge_gen u_edges (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bus_en_i (bus_en_i),
        .cpol_i   (cpol_i),
        .tick_i   (tick),
        .lvl_o    (lvl),
        .rise_o   (rise_q),
        .fall_o   (fall_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= 1'b0;
        end else begin
            run_q <= bus_en_i;
        end
    end

    assign byp_live   = run_q && act_byp;
    assign sclk_o     = byp_live ? (cpol_i ^ clk_i) : (cpol_i ^ lvl);
    assign rise_stb_o = byp_live || rise_q;
    assign fall_stb_o = byp_live || fall_q;

    p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_en_i && !act_byp && !(tick && lvl)) |=> $stable(act_cfg));

    p_byp_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_en_i && act_byp) |=> !lvl);

endmodule

// File: tb/spi_dual_clkdiv_tb_top.sv
`timescale 1ns/1ps
module spi_dual_clkdiv_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0;
    logic       cpol = 1'b0;
    logic       sel = 1'b0;
    logic [3:0] ex = 4'd0;
    logic [7:0] ln = 8'd0;
    logic       sclk, rs, fs;

    always #4 clk = ~clk;

    spi_dual_clkdiv dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .bus_en_i   (bus_en),
        .cpol_i     (cpol),
        .div_sel_i  (sel),
        .exp_div_i  (ex),
        .lin_div_i  (ln),
        .sclk_o     (sclk),
        .rise_stb_o (rs),
        .fall_stb_o (fs)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // behavioural reference
    int m_cnt = 0;
    bit m_lvl = 0, m_run = 0, m_r = 0, m_f = 0;
    bit m_sel = 0;
    int m_ex = 0, m_ln = 0;

    function automatic int m_half(input bit s, input int e, input int n);
        if (s) return n + 1;
        return (2 ** e) / 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_lvl = 0; m_run = 0; m_r = 0; m_f = 0;
            m_sel = 0; m_ex = 0; m_ln = 0;
        end else if (!bus_en) begin
            m_cnt = 0; m_lvl = 0; m_run = 0; m_r = 0; m_f = 0;
            m_sel = sel; m_ex = ex; m_ln = ln;
        end else begin
            m_run = 1;
            if (!m_sel && m_ex == 0) begin
                m_sel = sel; m_ex = ex; m_ln = ln;
                m_cnt = 0; m_lvl = 0; m_r = 0; m_f = 0;
            end else if (m_cnt + 1 == m_half(m_sel, m_ex, m_ln)) begin
                m_cnt = 0;
                if (m_lvl) begin
                    m_sel = sel; m_ex = ex; m_ln = ln;
                end
                m_lvl = !m_lvl;
                m_r = (cpol ^ m_lvl);
                m_f = !(cpol ^ m_lvl);
            end else begin
                m_cnt++;
                m_r = 0; m_f = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit    byp;
            bit    e_s, e_r, e_f;
            string tg;
            byp = m_run && !m_sel && (m_ex == 0);
            e_s = byp ? cpol : (cpol ^ m_lvl);
            e_r = byp || m_r;
            e_f = byp || m_f;
            tg  = !m_run ? "R2" : (byp ? "R4" : (m_sel ? "R5" : "R3"));
            chk(sclk == e_s, tg, "model sclk", sclk, e_s);
            chk(rs == e_r, tg, "model rise (R8)", rs, e_r);
            chk(fs == e_f, tg, "model fall (R8)", fs, e_f);
        end
    end

    task automatic wait_edge(input bit want_rise);
        do @(negedge clk); while (!(want_rise ? rs : fs));
    endtask

    task automatic count_to(input bit want_rise, input int expv, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_rise ? rs : fs));
        chk(n == expv, tag, "strobe gap", n, expv);
    endtask

    task automatic restart(input bit s, input int e, input int n);
        @(negedge clk);
        bus_en = 0;
        @(negedge clk);
        sel = s; ex = 4'(e); ln = 8'(n);
        @(negedge clk);
        bus_en = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R3 R5 R10) actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(rs == 1'b0 && fs == 1'b0, "R1", "strobes in reset", rs | fs, 0);
        cpol = 1;
        @(negedge clk);
        chk(sclk == 1'b1, "R1", "sclk follows cpol in reset", sclk, 1);
        cpol = 0;
        rst = 0;

        // disabled: no activity
        sel = 0; ex = 1;
        begin
            int act = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (sclk != cpol || rs || fs) act++;
            end
            chk(act == 0, "R2", "activity while disabled", act, 0);
        end

        // power-of-two scheme
        restart(0, 1, 0);
        wait_edge(1); count_to(1, 2, "R3");
        restart(0, 3, 0);
        wait_edge(1); count_to(1, 8, "R3");
        count_to(0, 4, "R3");
        restart(0, 5, 0);
        wait_edge(1); count_to(1, 32, "R3");

        // select alone decides
        restart(0, 2, 200);
        wait_edge(1); count_to(1, 4, "R6");
        restart(1, 9, 2);
        wait_edge(1); count_to(1, 6, "R6");

        // linear scheme
        restart(1, 0, 0);
        wait_edge(1); count_to(1, 2, "R5");
        restart(1, 0, 255);
        wait_edge(1); count_to(1, 512, "R5");

        // strobe counts over a window, period 4
        restart(1, 0, 1);
        wait_edge(1);
        begin
            int nr = 0, nf = 0, nb = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (rs) nr++;
                if (fs) nf++;
                if (rs && fs) nb++;
            end
            chk(nr == 10, "R8", "rise count", nr, 10);
            chk(nf == 10, "R8", "fall count", nf, 10);
            chk(nb == 0, "R8", "simultaneous strobes", nb, 0);
        end

        // pass-through
        restart(0, 0, 0);
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R4", "sclk in low phase", sclk, 0);
        chk(rs && fs, "R4", "both strobes", int'(rs) + int'(fs), 2);
        @(posedge clk); #2;
        chk(sclk == 1'b1, "R4", "sclk in high phase", sclk, 1);
        count_to(1, 1, "R4");

        // cpol = 1
        @(negedge clk);
        bus_en = 0;
        cpol = 1;
        @(negedge clk);
        chk(sclk == 1'b1, "R9", "idle high", sclk, 1);
        chk(!rs && !fs, "R9", "no strobes idle", int'(rs) + int'(fs), 0);
        @(posedge clk); #2;
        chk(sclk == 1'b1, "R9", "idle high in high phase", sclk, 1);
        sel = 1; ln = 1;
        @(negedge clk);
        bus_en = 1;
        wait_edge(0);
        count_to(1, 2, "R9");
        count_to(0, 2, "R9");
        restart(0, 0, 0);
        repeat (2) @(posedge clk); #2;
        chk(sclk == 1'b0, "R9", "pass-through inverted", sclk, 0);
        @(negedge clk);
        bus_en = 0;
        cpol = 0;

        // mid-period change
        restart(1, 0, 3);
        wait_edge(1);
        ln = 0;
        count_to(0, 4, "R7");
        count_to(1, 1, "R7");
        count_to(1, 2, "R7");

        // maximum exponent
        restart(0, 15, 0);
        wait_edge(1);
        count_to(1, 32768, "R10");

        @(negedge clk);
        bus_en = 0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule